// File: doc/BRIEF.md
# Serial Audio Format Deserializer

This block takes a three-wire serial audio stream made of a bit clock, a word clock and a data line from an external source. It turns the stream into parallel left and right PCM samples of 24 bits each. All three wires pass through a synchronizer into a faster system clock. The block finds the rising bit-clock edges by edge detection, samples the word clock and the data on each of them, counts bit slots within every half of the word clock, and assembles the sample that the selected format places in that half.

A static 2-bit select chooses one of four layouts. In the left-justified layout the sample sits at the start of each half. In the I2S layout the sample starts one slot after the word-clock change. In the two right-justified layouts, 24-bit and 16-bit, the sample sits at the end of each half. A separate polarity control inverts the word clock before decoding, so the block accepts a stream whose word clock runs with the opposite sense, such as a 16-bit right-justified source that marks the left channel with a low word clock. The block emits each complete stereo pair with a single-cycle strobe.

Top module: `serial_audio_deser`

## Requirements
- R1: `fmt_sel` picks the layout. 0 means 24-bit left-justified, 1 means I2S, 2 means 24-bit right-justified and 3 means 16-bit right-justified. It is held static while the stream runs, and a change takes effect after a reset.
- R2: The word clock and the data are synchronized into `clk` and sampled once for each rising edge of the bit clock. Each rising edge is one bit slot, and no slot is ever sampled twice.
- R3: In left-justified mode the sample is the first 24 slots of each word-clock half, MSB first. Any slots after those are ignored. A high word clock marks the left channel. Halves are at least 24 slots long.
- R4: In I2S mode the MSB arrives in the second slot of a half, one bit clock after the word-clock change, and the 23 following slots carry the remaining bits. The first slot and any trailing slots are ignored. A low word clock marks the left channel. Halves are at least 25 slots long.
- R5: In 24-bit right-justified mode the sample is the last 24 slots before the word-clock change, MSB first. Any leading slots are ignored, so any half length of 24 slots or more works. A high word clock marks the left channel.
- R6: In 16-bit right-justified mode the sample is the last 16 slots of each half. It appears in bits 23:8 of the output, and bits 7:0 are zero. A high word clock marks the left channel. Any half length of 16 slots or more works.
- R7: With `wclk_inv` = 1 the word clock is inverted before decoding, so the opposite level marks the left channel in every mode.
- R8: `pair_valid` is high for exactly one `clk` cycle after each right half completes. That half completes at the word-clock change that ends it. At the pulse, `left_out` holds the preceding left half and `right_out` holds the right half. Both outputs keep their values until the next pulse.
- R9: After reset, the half in progress when decoding starts is discarded. A right half without a complete left half before it produces no pulse.
- R10: In reset and after reset, until the first pair arrives, `pair_valid` is low and both outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst | input | 1 | Synchronous active-high reset |
| fmt_sel | input | 2 | Static layout select (see R1) |
| wclk_inv | input | 1 | Inverts the word clock before decoding |
| bclk_in | input | 1 | Serial bit clock, asynchronous |
| wclk_in | input | 1 | Serial word clock, asynchronous |
| sdata_in | input | 1 | Serial data, asynchronous |
| left_out | output | 24 | Left sample of the latest pair |
| right_out | output | 24 | Right sample of the latest pair |
| pair_valid | output | 1 | One-cycle strobe for a new stereo pair |

## Verification
The bench drives each layout at its minimum half length and at a longer padded length. A slot-offset error then shows up as a shifted sample, and a right-justified decoder that counted from the start of the half, rather than keeping the tail, would return padding for long halves. The padding alternates between 0 and 1, so a design that captured one slot too many, or did not zero the low byte in 16-bit mode, fails the compare. Runs with the word clock inverted, in 16-bit right-justified and I2S modes, expose a swapped channel. Runs that begin with a lone right half catch a design that pairs a right half without a complete left half or keeps the partial half in progress when decoding starts.

// File: rtl/saud_pkg.sv
package saud_pkg;

    localparam int SAMPLE_W = 24;
    localparam int NARROW_W = 16;

    typedef enum logic [1:0] {
        FMT_LJ24 = 2'd0,
        FMT_I2S  = 2'd1,
        FMT_RJ24 = 2'd2,
        FMT_RJ16 = 2'd3
    } fmt_e;

    // One sampled bit slot, produced on a bit-clock rising edge
    typedef struct packed {
        logic valid;
        logic wclk;
        logic data;
    } bit_evt_t;

    // A finished half-frame
    typedef struct packed {
        logic                valid;
        logic                is_left;
        logic [SAMPLE_W-1:0] word;
    } half_res_t;

    // Word-clock level that marks the left channel (before inversion)
    function automatic logic left_level(fmt_e f);
        return (f == FMT_I2S) ? 1'b0 : 1'b1;
    endfunction

    // First slot of a half that carries the MSB for leading layouts
    function automatic int lead_offset(fmt_e f);
        return (f == FMT_I2S) ? 1 : 0;
    endfunction

    // Select the sample from the leading or trailing capture register
    function automatic logic [SAMPLE_W-1:0] pick_word(fmt_e f,
                                                      logic [SAMPLE_W-1:0] lead,
                                                      logic [SAMPLE_W-1:0] tail);
        logic [SAMPLE_W-1:0] w;
        case (f)
            FMT_LJ24, FMT_I2S: w = lead;
            FMT_RJ24:          w = tail;
            default:           w = {tail[NARROW_W-1:0], {(SAMPLE_W-NARROW_W){1'b0}}};
        endcase
        return w;
    endfunction

endpackage

// File: rtl/saud_sync.sv
module saud_sync
    import saud_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     wclk_inv,
    input  logic     bclk_in,
    input  logic     wclk_in,
    input  logic     sdata_in,
    output bit_evt_t evt
);

    localparam int LAST = SYNC_STAGES - 1;

    // bit 2: bit clock, bit 1: word clock, bit 0: data
    logic [2:0] stg_q [SYNC_STAGES];
    logic       bclk_d_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SYNC_STAGES; i++) stg_q[i] <= '0;
            bclk_d_q <= 1'b0;
        end else begin
            stg_q[0] <= {bclk_in, wclk_in, sdata_in};
            for (int i = 1; i < SYNC_STAGES; i++) stg_q[i] <= stg_q[i-1];
            bclk_d_q <= stg_q[LAST][2];
        end
    end

    always_comb begin
        evt.valid = stg_q[LAST][2] & ~bclk_d_q;
        evt.wclk  = stg_q[LAST][1] ^ wclk_inv;
        evt.data  = stg_q[LAST][0];
    end

    // R2: a bit clock edge yields a single slot, never two in a row
    a_r2_one_slot_per_edge: assert property (@(posedge clk) disable iff (rst)
        evt.valid |=> !evt.valid);

endmodule

// File: rtl/saud_slot.sv
module saud_slot
    import saud_pkg::*;
#(
    parameter int SLOT_W = 6
) (
    input  logic      clk,
    input  logic      rst,
    input  fmt_e      fmt,
    input  bit_evt_t  evt,
    output half_res_t res
);

    localparam int SLOT_MAX = (1 << SLOT_W) - 1;

    logic                have_prev_q;
    logic                started_q;
    logic                prev_w_q;
    logic [SLOT_W-1:0]   slot_q;
    logic [SAMPLE_W-1:0] lead_q;
    logic [SAMPLE_W-1:0] tail_q;
    half_res_t           res_q;

    logic                edge_w;
    logic [SLOT_W-1:0]   cur_slot;
    logic [SLOT_W-1:0]   slot_nxt;
    logic                take_bit;
    int                  first_slot;

    always_comb begin
        edge_w     = evt.valid && have_prev_q && (evt.wclk != prev_w_q);
        cur_slot   = edge_w ? '0 : slot_q;
        slot_nxt   = (int'(cur_slot) == SLOT_MAX) ? cur_slot : cur_slot + 1'b1;
        first_slot = lead_offset(fmt);
        take_bit   = (int'(cur_slot) >= first_slot) &&
                     (int'(cur_slot) <  first_slot + SAMPLE_W);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            have_prev_q <= 1'b0;
            started_q   <= 1'b0;
            prev_w_q    <= 1'b0;
            slot_q      <= '0;
            lead_q      <= '0;
            tail_q      <= '0;
            res_q       <= '0;
        end else begin
            res_q.valid <= 1'b0;
            if (evt.valid) begin
                have_prev_q <= 1'b1;
                prev_w_q    <= evt.wclk;
                slot_q      <= slot_nxt;
                // trailing window: always the most recent slots of this half
                tail_q <= edge_w ? {{(SAMPLE_W-1){1'b0}}, evt.data}
                                 : {tail_q[SAMPLE_W-2:0], evt.data};
                // leading window: only slots inside the capture range
                if (edge_w)
                    lead_q <= take_bit ? {{(SAMPLE_W-1){1'b0}}, evt.data} : '0;
                else if (take_bit)
                    lead_q <= {lead_q[SAMPLE_W-2:0], evt.data};
                if (edge_w) begin
                    started_q <= 1'b1;
                    if (started_q) begin
                        res_q.valid   <= 1'b1;
                        res_q.is_left <= (prev_w_q == left_level(fmt));
                        res_q.word    <= pick_word(fmt, lead_q, tail_q);
                    end
                end
            end
        end
    end

    assign res = res_q;

    // R9: no half is reported before a full half has begun
    a_r9_no_partial_half: assert property (@(posedge clk) disable iff (rst)
        res.valid |-> $past(started_q));

endmodule

// File: rtl/saud_pair.sv
module saud_pair
    import saud_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  half_res_t           res,
    output logic [SAMPLE_W-1:0] left_out,
    output logic [SAMPLE_W-1:0] right_out,
    output logic                pair_valid
);

    logic [SAMPLE_W-1:0] hold_l_q;
    logic                have_l_q;
    logic [SAMPLE_W-1:0] left_q;
    logic [SAMPLE_W-1:0] right_q;
    logic                valid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_l_q <= '0;
            have_l_q <= 1'b0;
            left_q   <= '0;
            right_q  <= '0;
            valid_q  <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (res.valid) begin
                if (res.is_left) begin
                    hold_l_q <= res.word;
                    have_l_q <= 1'b1;
                end else if (have_l_q) begin
                    left_q   <= hold_l_q;
                    right_q  <= res.word;
                    valid_q  <= 1'b1;
                    have_l_q <= 1'b0;
                end
            end
        end
    end

    assign left_out   = left_q;
    assign right_out  = right_q;
    assign pair_valid = valid_q;

    // R8: strobe is a single cycle
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
        pair_valid |=> !pair_valid);

    // R8: outputs only move together with the strobe
    a_r8_hold_outputs: assert property (@(posedge clk) disable iff (rst)
        !pair_valid |-> ($stable(left_out) && $stable(right_out)));

    // R9: a pair is only released when a left half was waiting
    a_r9_left_first: assert property (@(posedge clk) disable iff (rst)
        pair_valid |-> $past(have_l_q));

    // R10: nothing is emitted in the cycle after reset
    a_r10_quiet_after_reset: assert property (@(posedge clk)
        $past(rst) |-> !pair_valid);

endmodule

// File: rtl/serial_audio_deser.sv
module serial_audio_deser
    import saud_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int SLOT_W      = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [1:0]          fmt_sel,
    input  logic                wclk_inv,
    input  logic                bclk_in,
    input  logic                wclk_in,
    input  logic                sdata_in,
    output logic [SAMPLE_W-1:0] left_out,
    output logic [SAMPLE_W-1:0] right_out,
    output logic                pair_valid
);

    fmt_e      fmt;
    bit_evt_t  evt;
    half_res_t res;

    assign fmt = fmt_e'(fmt_sel);

    saud_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .wclk_inv (wclk_inv),
        .bclk_in  (bclk_in),
        .wclk_in  (wclk_in),
        .sdata_in (sdata_in),
        .evt      (evt)
    );

    saud_slot #(.SLOT_W(SLOT_W)) u_slot (
        .clk (clk),
        .rst (rst),
        .fmt (fmt),
        .evt (evt),
        .res (res)
    );

    saud_pair u_pair (
        .clk        (clk),
        .rst        (rst),
        .res        (res),
        .left_out   (left_out),
        .right_out  (right_out),
        .pair_valid (pair_valid)
    );

    // R6: the narrow layout never carries data in the low byte
    a_r6_pad_zero: assert property (@(posedge clk) disable iff (rst)
        (pair_valid && fmt == FMT_RJ16) |-> (left_out[7:0] == 8'h00 && right_out[7:0] == 8'h00));

endmodule

// File: tb/test_serial_audio_deser.sv
module test_serial_audio_deser;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  fmt_sel = 2'd0;
    logic        wclk_inv = 1'b0;
    logic        bclk = 1'b0;
    logic        wclk = 1'b0;
    logic        sdata = 1'b0;
    logic [23:0] left_out;
    logic [23:0] right_out;
    logic        pair_valid;

    always #10 clk = ~clk;   // 50 MHz

    serial_audio_deser i_serial_audio_deser (
        .clk        (clk),
        .rst        (rst),
        .fmt_sel    (fmt_sel),
        .wclk_inv   (wclk_inv),
        .bclk_in    (bclk),
        .wclk_in    (wclk),
        .sdata_in   (sdata),
        .left_out   (left_out),
        .right_out  (right_out),
        .pair_valid (pair_valid)
    );

    int          n_vec = 0;
    int          n_bad = 0;
    logic [47:0] expq[$];
    logic [47:0] last_pair = '0;
    logic        prev_valid = 1'b0;
    string       cur_req = "R10";
    bit          done = 1'b0;

    // Reference comparison on every clock, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            if (pair_valid) begin
                n_vec++;
                if (prev_valid) begin
                    n_bad++;
                    $display("FAIL R8: strobe longer than one cycle actual=1 expected=0");
                end
                if (expq.size() == 0) begin
                    n_bad++;
                    $display("FAIL %s: unexpected pair actual=%h expected=none",
                             cur_req, {left_out, right_out});
                end else begin
                    logic [47:0] e;
                    e = expq.pop_front();
                    last_pair = e;
                    if ({left_out, right_out} !== e) begin
                        n_bad++;
                        $display("FAIL %s: pair actual=%h expected=%h",
                                 cur_req, {left_out, right_out}, e);
                    end
                end
            end
        end
        prev_valid = pair_valid;
    end

    // R2: data and word clock change while the bit clock is low, sampled at its rise
    task automatic send_bit(input logic w, input logic d);
        @(negedge clk);
        bclk  = 1'b0;
        wclk  = w;
        sdata = d;
        repeat (3) @(negedge clk);
        bclk = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    function automatic logic bit_at(input int f, input logic [23:0] s,
                                    input int k, input int hb);
        logic junk;
        junk = k[0];
        case (f)
            0: return (k < 24) ? s[23-k] : junk;
            1: return (k >= 1 && k <= 24) ? s[24-k] : junk;
            2: return (k >= hb-24) ? s[hb-1-k] : junk;
            default: return (k >= hb-16) ? s[23-(k-(hb-16))] : junk;
        endcase
    endfunction

    task automatic send_half(input int f, input logic lvl, input logic [23:0] s,
                             input int hb);
        for (int k = 0; k < hb; k++) send_bit(lvl ^ wclk_inv, bit_at(f, s, k, hb));
    endtask

    task automatic run(input int f, input logic inv, input int hb, input int nfr,
                       input bit orphan, input string req);
        logic lvl_l;
        logic [23:0] l, r;
        lvl_l    = (f == 1) ? 1'b0 : 1'b1;
        fmt_sel  = f[1:0];
        wclk_inv = inv;
        @(negedge clk);
        rst  = 1'b1;
        bclk = 1'b0;
        wclk = (~lvl_l) ^ inv;
        repeat (4) @(negedge clk);
        // R10: reset state
        n_vec++;
        if (pair_valid !== 1'b0 || left_out !== 24'h0 || right_out !== 24'h0) begin
            n_bad++;
            $display("FAIL R10: reset state actual=%b %h %h expected=0 0 0",
                     pair_valid, left_out, right_out);
        end
        rst = 1'b0;
        cur_req = req;
        last_pair = '0;
        if (orphan) begin
            // R9: dummy left half, then a right half with no full left before it
            send_half(f, lvl_l, $urandom, hb);
            send_half(f, ~lvl_l, $urandom, hb);
        end else begin
            send_half(f, ~lvl_l, $urandom, hb);
        end
        for (int n = 0; n < nfr; n++) begin
            l = $urandom;
            r = $urandom;
            if (f == 3) expq.push_back({l[23:8], 8'h00, r[23:8], 8'h00});
            else        expq.push_back({l, r});
            send_half(f, lvl_l, l, hb);
            send_half(f, ~lvl_l, r, hb);
        end
        send_half(f, lvl_l, $urandom, hb);   // its opening edge closes the last pair
        repeat (20) @(negedge clk);
        n_vec++;
        if (expq.size() != 0) begin
            n_bad++;
            $display("FAIL %s: missing pairs actual=%0d expected=0", req, expq.size());
            expq.delete();
        end
        // R8: outputs hold the last pair after the strobe
        n_vec++;
        if ({left_out, right_out} !== last_pair) begin
            n_bad++;
            $display("FAIL R8: held pair actual=%h expected=%h",
                     {left_out, right_out}, last_pair);
        end
    endtask

    initial begin
        // R1: every select code is used below
        run(0, 1'b0, 32, 5, 1'b0, "R1 R3");
        run(0, 1'b0, 24, 5, 1'b0, "R3");
        run(1, 1'b0, 32, 5, 1'b0, "R1 R4");
        run(1, 1'b0, 25, 5, 1'b0, "R4");
        run(2, 1'b0, 32, 5, 1'b0, "R1 R5");
        run(2, 1'b0, 24, 5, 1'b0, "R5");
        run(3, 1'b0, 32, 5, 1'b0, "R1 R6");
        run(3, 1'b0, 16, 5, 1'b0, "R6");
        run(3, 1'b1, 32, 5, 1'b0, "R7");
        run(1, 1'b1, 32, 4, 1'b0, "R7");
        run(0, 1'b0, 32, 3, 1'b1, "R9");
        run(2, 1'b0, 48, 3, 1'b1, "R9");
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: run hung actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule